// File: doc/BRIEF.md
# Single-wire bus master sequencer

This block is the master side of a bus that has a single open-drain data line, shared with one or more slave devices and held high by an external pull-up. The master never drives the line high. It either pulls the line low through `lineOe` or releases it, and it reads the line back through `lineIn`. A host starts one phase at a time with a start strobe. A phase is a bus reset with presence detection, a command byte write, a data byte write or a data byte read. Bytes go out and come in least significant bit first, one timed slot per bit. All timing is derived from a cycles-per-microsecond parameter.

A sequencer sits in front of the bus engine and enforces the access order. The first step is a reset that found a device. Next comes one addressing command, then one function command, and each may be followed by data bytes. When the addressing command is one of the two search codes, no function command is accepted, and the host must issue a new reset. A request that breaks the order is refused with an error flag and a done pulse, and the line is never touched. While the host stalls between phases the line stays released, so the host may pause for any length of time.

Top module: `sw_master`

## Requirements
- R1: After reset, `lineOe`, `busy`, `done`, `presence` and `seqErr` are all 0.
- R2: A reset phase (`phase`=2'b00) pulls the line low for exactly RST_LOW_US microseconds (at least 480). It then releases the line, and `done` rises RST_WIN_US microseconds after the release.
- R3: `presence` is 1 after a reset phase exactly when the line reads low at PRES_US microseconds after the release. It is cleared when a reset phase starts.
- R4: A byte write sends bit 0 first. A 1 bit pulls the line low for W1_US microseconds and a 0 bit for W0_US microseconds. Each bit slot is SLOT_US microseconds from one falling edge to the next.
- R5: A byte read (`phase`=2'b10) pulls the line low for RD_US microseconds in each slot. It samples the line at RDS_US microseconds into the slot. The first bit received ends up in `rdData` bit 0.
- R6: A data write (`phase`=2'b01), a data read or a command write is refused unless a reset with presence came before it. A refused request raises `seqErr` together with a one-cycle `done`, and it causes no activity on the line.
- R7: After a reset with presence, the first command write (`phase`=2'b11) is the addressing command and the second is the function command. A third command write before a new reset is refused.
- R8: After an addressing command of 8'hF0 or 8'hEC, any further command write is refused until a new reset. Data reads and writes are still accepted.
- R9: The line is released whenever `busy` is 0, so an idle gap of any length between phases leaves it high.
- R10: A start strobe that arrives while a phase is running is ignored.
- R11: `done` is a single-cycle pulse that ends every accepted or refused request, and `busy` stays high from acceptance until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| phase | input | 2 | 00 reset, 01 data write, 10 data read, 11 command write |
| wrData | input | 8 | Byte to send for write phases |
| rdData | output | 8 | Byte received, valid from the done pulse of a read phase |
| busy | output | 1 | A request is being handled |
| done | output | 1 | One-cycle end-of-request pulse |
| presence | output | 1 | A device answered the last reset |
| seqErr | output | 1 | Last request was refused by the order rules |
| lineOe | output | 1 | 1 pulls the shared line low, 0 releases it |
| lineIn | input | 1 | Level of the shared line |

## Verification
Assertions check on every cycle that the line is released whenever the block is idle. They also check that a slot only starts its pull from a released line and that reads sample only after the line has been let go. The done pulse is checked to last one cycle, the order checker is checked to refuse third commands and commands after a search, and a start strobe during a slot is checked to leave the sequence state unchanged. The bench's scenarios show the behaviours that need a slave and a stopwatch. These are the exact reset, write-1, write-0 and read pulse widths, the slot period, the bit order in both directions, presence against a slave that stays silent, and the absence of any line activity on refused requests.

// File: rtl/sw_pkg.sv
package sw_pkg;

  typedef enum logic [1:0] {
    PH_RESET  = 2'b00,
    PH_WRDATA = 2'b01,
    PH_RDDATA = 2'b10,
    PH_WRCMD  = 2'b11
  } phase_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RSTLOW, ST_RSTWAIT, ST_SLOT, ST_DONE
  } state_t;

  typedef enum logic [2:0] {
    SQ_NONE, SQ_READY, SQ_ADDR, SQ_FUNC, SQ_SEARCH
  } seq_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tmrClr;
    logic drvSet;
    logic drvRel;
    logic shLoad;
    logic shIn;
    logic shOut;
    logic bitClr;
    logic bitInc;
    logic presClr;
    logic presCap;
  } strobe_t;

  localparam logic [7:0] CMD_SEARCH       = 8'hF0;
  localparam logic [7:0] CMD_ALARM_SEARCH = 8'hEC;

endpackage

// File: rtl/sw_datapath.sv
module sw_datapath
  import sw_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [7:0]    wrData,
  input  logic          lineIn,
  output logic [TW-1:0] tmr,
  output logic          curBit,
  output logic          bitLast,
  output logic [7:0]    shReg,
  output logic          presence,
  output logic          lineOe
);

  logic [2:0] bitCnt;
  logic lineS1, lineS2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineS1   <= 1'b1;
      lineS2   <= 1'b1;
      tmr      <= '0;
      lineOe   <= 1'b0;
      shReg    <= '0;
      bitCnt   <= '0;
      presence <= 1'b0;
    end else begin
      lineS1 <= lineIn;
      lineS2 <= lineS1;
      tmr    <= stb.tmrClr ? '0 : tmr + 1'b1;
      if (stb.drvSet)      lineOe <= 1'b1;
      else if (stb.drvRel) lineOe <= 1'b0;
      if (stb.shLoad)      shReg <= wrData;
      else if (stb.shIn)   shReg <= {lineS2, shReg[7:1]};
      else if (stb.shOut)  shReg <= {1'b1, shReg[7:1]};
      if (stb.bitClr)      bitCnt <= '0;
      else if (stb.bitInc) bitCnt <= bitCnt + 3'd1;
      if (stb.presClr)     presence <= 1'b0;
      else if (stb.presCap) presence <= !lineS2;
    end
  end

  assign curBit  = shReg[0];
  assign bitLast = (bitCnt == 3'd7);

  // R9: a pull may only start from a released line
  a_r9_set_from_released: assert property (@(posedge clk) disable iff (!rstN)
    stb.drvSet |-> !lineOe);

  // R5: the line must be released when a read bit is sampled
  a_r5_sample_released: assert property (@(posedge clk) disable iff (!rstN)
    stb.shIn |-> !lineOe);

endmodule

// File: rtl/sw_ctrl.sv
module sw_ctrl
  import sw_pkg::*;
#(
  parameter int TW        = 16,
  parameter int RST_LOW_C = 480,
  parameter int RST_WIN_C = 480,
  parameter int PRES_C    = 70,
  parameter int SLOT_C    = 70,
  parameter int W1_C      = 6,
  parameter int W0_C      = 60,
  parameter int RD_C      = 6,
  parameter int RDS_C     = 15
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [1:0]    phase,
  input  logic [7:0]    wrData,
  input  logic [TW-1:0] tmr,
  input  logic          curBit,
  input  logic          bitLast,
  input  logic          presence,
  output strobe_t       stb,
  output logic          busy,
  output logic          done,
  output logic          seqErr
);

  localparam logic [TW-1:0] RL_END   = TW'(RST_LOW_C - 1);
  localparam logic [TW-1:0] WIN_END  = TW'(RST_WIN_C - 1);
  localparam logic [TW-1:0] PRES_AT  = TW'(PRES_C - 1);
  localparam logic [TW-1:0] SLOT_END = TW'(SLOT_C - 1);
  localparam logic [TW-1:0] W1_END   = TW'(W1_C - 1);
  localparam logic [TW-1:0] W0_END   = TW'(W0_C - 1);
  localparam logic [TW-1:0] RD_END   = TW'(RD_C - 1);
  localparam logic [TW-1:0] RDS_AT   = TW'(RDS_C - 1);

  state_t state, nextState;
  seq_t   stage;
  phase_t phT;
  logic   isRead, accept, errReg;
  logic [TW-1:0] lowEnd;

  assign phT    = phase_t'(phase);
  assign lowEnd = isRead ? RD_END : (curBit ? W1_END : W0_END);

  always_comb begin
    case (phT)
      PH_RESET: accept = 1'b1;
      PH_WRCMD: accept = (stage == SQ_READY) || (stage == SQ_ADDR);
      default:  accept = (stage == SQ_ADDR) || (stage == SQ_FUNC) || (stage == SQ_SEARCH);
    endcase
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (start) begin
        if (!accept) nextState = ST_DONE;
        else if (phT == PH_RESET) begin
          stb.drvSet = 1'b1; stb.tmrClr = 1'b1; stb.presClr = 1'b1;
          nextState = ST_RSTLOW;
        end else begin
          stb.drvSet = 1'b1; stb.tmrClr = 1'b1; stb.bitClr = 1'b1;
          stb.shLoad = (phT != PH_RDDATA);
          nextState  = ST_SLOT;
        end
      end
      ST_RSTLOW: if (tmr == RL_END) begin
        stb.drvRel = 1'b1; stb.tmrClr = 1'b1;
        nextState  = ST_RSTWAIT;
      end
      ST_RSTWAIT: begin
        stb.presCap = (tmr == PRES_AT);
        if (tmr == WIN_END) nextState = ST_DONE;
      end
      ST_SLOT: begin
        stb.drvRel = (tmr == lowEnd);
        stb.shIn   = isRead && (tmr == RDS_AT);
        if (tmr == SLOT_END) begin
          stb.shOut = !isRead;
          if (bitLast) nextState = ST_DONE;
          else begin
            stb.bitInc = 1'b1; stb.tmrClr = 1'b1; stb.drvSet = 1'b1;
          end
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      stage  <= SQ_NONE;
      isRead <= 1'b0;
      errReg <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && start) begin
        errReg <= !accept;
        if (accept) begin
          isRead <= (phT == PH_RDDATA);
          case (phT)
            PH_RESET: stage <= SQ_NONE;
            PH_WRCMD: stage <= (stage != SQ_READY) ? SQ_FUNC :
                               ((wrData == CMD_SEARCH || wrData == CMD_ALARM_SEARCH) ? SQ_SEARCH : SQ_ADDR);
            default: ;
          endcase
        end
      end
      if (state == ST_RSTWAIT && tmr == WIN_END)
        stage <= presence ? SQ_READY : SQ_NONE;
    end
  end

  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_DONE);
  assign seqErr = errReg;

  // R7: a third command before a new reset is refused
  a_r7_third_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start && phT == PH_WRCMD && stage == SQ_FUNC) |=> (seqErr && done));

  // R8: after a search-type addressing command no command is taken
  a_r8_search_lock: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start && phT == PH_WRCMD && stage == SQ_SEARCH) |=> (seqErr && done));

  // R10: a strobe during a slot changes no sequence state
  a_r10_ignore_start: assert property (@(posedge clk) disable iff (!rstN)
    (start && state == ST_SLOT) |=> ($stable(stage) && $stable(isRead)));

endmodule

// File: rtl/sw_master.sv
module sw_master
  import sw_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int RST_LOW_US = 480,
  parameter int RST_WIN_US = 480,
  parameter int PRES_US    = 70,
  parameter int SLOT_US    = 70,
  parameter int W1_US      = 6,
  parameter int W0_US      = 60,
  parameter int RD_US      = 6,
  parameter int RDS_US     = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] phase,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic       seqErr,
  output logic       lineOe,
  input  logic       lineIn
);

  localparam int RST_LOW_C = RST_LOW_US * CYC_PER_US;
  localparam int RST_WIN_C = RST_WIN_US * CYC_PER_US;
  localparam int MAX_C     = (RST_LOW_C > RST_WIN_C) ? RST_LOW_C : RST_WIN_C;
  localparam int TW        = $clog2(MAX_C + 1);

  strobe_t       stb;
  logic [TW-1:0] tmr;
  logic          curBit, bitLast;

  sw_ctrl #(
    .TW(TW), .RST_LOW_C(RST_LOW_C), .RST_WIN_C(RST_WIN_C),
    .PRES_C(PRES_US * CYC_PER_US), .SLOT_C(SLOT_US * CYC_PER_US),
    .W1_C(W1_US * CYC_PER_US), .W0_C(W0_US * CYC_PER_US),
    .RD_C(RD_US * CYC_PER_US), .RDS_C(RDS_US * CYC_PER_US)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .phase(phase), .wrData(wrData),
    .tmr(tmr), .curBit(curBit), .bitLast(bitLast), .presence(presence),
    .stb(stb), .busy(busy), .done(done), .seqErr(seqErr)
  );

  sw_datapath #(.TW(TW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .lineIn(lineIn),
    .tmr(tmr), .curBit(curBit), .bitLast(bitLast), .shReg(rdData),
    .presence(presence), .lineOe(lineOe)
  );

  // R9: idle means released
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !lineOe);

  // R11: done lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11: busy holds until the done pulse
  a_r11_busy_to_done: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

// File: tb/sw_master_bench.sv
module sw_master_bench;

  localparam logic [1:0] OP_RST = 2'b00;
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_RD  = 2'b10;
  localparam logic [1:0] OP_CMD = 2'b11;

  // {op, byte, expected seqErr, slave byte}
  localparam int NV = 17;
  localparam logic [18:0] VEC [NV] = '{
    {OP_RST, 8'h00, 1'b0, 8'h00},
    {OP_CMD, 8'hCC, 1'b0, 8'h00},
    {OP_CMD, 8'h44, 1'b0, 8'h00},
    {OP_CMD, 8'hBE, 1'b1, 8'h00},
    {OP_RD,  8'h00, 1'b0, 8'hA5},
    {OP_WR,  8'h3C, 1'b0, 8'h00},
    {OP_RST, 8'h00, 1'b0, 8'h00},
    {OP_CMD, 8'hF0, 1'b0, 8'h00},
    {OP_RD,  8'h00, 1'b0, 8'h5A},
    {OP_CMD, 8'h44, 1'b1, 8'h00},
    {OP_RST, 8'h00, 1'b0, 8'h00},
    {OP_CMD, 8'hEC, 1'b0, 8'h00},
    {OP_CMD, 8'h48, 1'b1, 8'h00},
    {OP_RST, 8'h00, 1'b0, 8'h00},
    {OP_CMD, 8'h55, 1'b0, 8'h00},
    {OP_WR,  8'h81, 1'b0, 8'h00},
    {OP_CMD, 8'hB8, 1'b0, 8'h00}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [1:0] phase = 2'b00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic busy, done, presence, seqErr, lineOe, lineIn;
  logic slaveLow = 1'b0;

  always #5 clk = ~clk;
  assign lineIn = ~(lineOe | slaveLow);

  sw_master #(.CYC_PER_US(1)) u_sw_master (
    .clk(clk), .rstN(rstN), .start(start), .phase(phase), .wrData(wrData),
    .rdData(rdData), .busy(busy), .done(done), .presence(presence),
    .seqErr(seqErr), .lineOe(lineOe), .lineIn(lineIn)
  );

  int nChecks = 0, nErr = 0, cyc = 0;
  int lowCnt = 0, slotCnt = 0, rstCnt = 0, riseCnt = 0;
  int rstLen = 0, relStamp = 0, lastRise = 0, prevRise = 0;
  int presWait = 0, hold = 0, txIdx = 0;
  int lens [8];
  logic prevOe = 1'b0, presEn = 1'b1, txEn = 1'b0;
  logic [7:0] txByte = 8'h00, capByte = 8'h00;

  always @(posedge clk) cyc <= cyc + 1;

  // slave model and line monitor, all at the falling clock edge
  always @(negedge clk) begin
    if (hold > 0) hold = hold - 1;
    if (presWait > 0) begin
      presWait = presWait - 1;
      if (presWait == 0) hold = 100;
    end
    if (lineOe && !prevOe) begin
      lowCnt = 1; riseCnt = riseCnt + 1;
      prevRise = lastRise; lastRise = cyc;
      if (txEn) begin
        if (!txByte[txIdx[2:0]]) hold = 30;
        txIdx = txIdx + 1;
      end
    end else if (lineOe) lowCnt = lowCnt + 1;
    else if (prevOe) begin
      if (lowCnt >= 400) begin
        rstLen = lowCnt; rstCnt = rstCnt + 1; relStamp = cyc;
        if (presEn) presWait = 15;
      end else begin
        lens[slotCnt % 8] = lowCnt;
        capByte = {(lowCnt < 30), capByte[7:1]};
        slotCnt = slotCnt + 1;
      end
    end
    prevOe = lineOe;
    slaveLow = (hold > 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] op, input logic [7:0] d);
    int guard = 0;
    @(negedge clk);
    phase = op; wrData = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    int sc, rc, rr;
    repeat (3) @(negedge clk);
    chk(lineOe == 0 && busy == 0 && done == 0, "R1 reset outputs", {lineOe, busy, done}, 0);
    chk(presence == 0 && seqErr == 0, "R1 reset flags", {presence, seqErr}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // data write before any reset: refused, no line activity
    sc = slotCnt; rc = riseCnt;
    runOp(OP_WR, 8'h12);
    chk(seqErr == 1, "R6 data before reset", seqErr, 1);
    chk(riseCnt == rc && slotCnt == sc, "R6 no line activity", riseCnt - rc, 0);
    @(negedge clk);
    chk(done == 0, "R11 done one cycle", done, 0);

    // reset with a silent slave
    presEn = 1'b0;
    runOp(OP_RST, 8'h00);
    chk(presence == 0, "R3 no presence", presence, 0);
    runOp(OP_CMD, 8'hCC);
    chk(seqErr == 1, "R6 command after silent reset", seqErr, 1);
    presEn = 1'b1;

    // reset timing with a slave answering
    runOp(OP_RST, 8'h00);
    chk(rstLen == 480, "R2 reset low width", rstLen, 480);
    chk(cyc - relStamp == 480, "R2 release to done", cyc - relStamp, 480);
    chk(presence == 1, "R3 presence seen", presence, 1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] d, tx;
      logic expErr;
      {op, d, expErr, tx} = VEC[i];
      txByte = tx; txIdx = 0; txEn = (op == OP_RD);
      sc = slotCnt;
      runOp(op, d);
      txEn = 1'b0;
      chk(seqErr == expErr, "R6/R7/R8 order rule", seqErr, expErr);
      if (expErr) chk(slotCnt == sc, "R6 refused is silent", slotCnt - sc, 0);
      else if (op == OP_RST) chk(presence == 1, "R3 presence", presence, 1);
      else if (op == OP_RD) chk(rdData == tx, "R5 read byte lsb first", rdData, tx);
      else chk(capByte == d, "R4 write byte lsb first", capByte, d);
      @(negedge clk);
    end

    // pulse widths and slot period (stage is now after function command)
    runOp(OP_WR, 8'h01);
    chk(lens[0] == 6, "R4 write-1 width", lens[0], 6);
    chk(lens[1] == 60, "R4 write-0 width", lens[1], 60);
    chk(lastRise - prevRise == 70, "R4 slot period", lastRise - prevRise, 70);
    txByte = 8'hFF; txIdx = 0; txEn = 1'b1;
    runOp(OP_RD, 8'h00);
    txEn = 1'b0;
    chk(lens[7] == 6, "R5 read low width", lens[7], 6);
    chk(rdData == 8'hFF, "R5 read all ones", rdData, 8'hFF);

    // start during a running write is ignored
    sc = slotCnt; rr = rstCnt;
    @(negedge clk);
    phase = OP_WR; wrData = 8'h0F; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    phase = OP_RST; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int g = 0;
      while (!done && g < 5000) begin @(negedge clk); g++; end
    end
    chk(slotCnt - sc == 8 && rstCnt == rr, "R10 start while busy", slotCnt - sc, 8);
    chk(capByte == 8'h0F, "R10 byte intact", capByte, 8'h0F);

    // long stall between phases keeps line released
    rc = riseCnt;
    repeat (500) @(negedge clk);
    chk(riseCnt == rc && lineIn == 1, "R9 idle released", riseCnt - rc, 0);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule